// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block supplies the two ALU source operands of a simple in-order pipeline. Each cycle it compares the two source register numbers of the instruction sitting in decode with the destination numbers of the instructions in the execute and memory stages. For each operand it then picks one of three values: the execute-stage result, the memory-stage result, or the value read from the register file. The picked value is captured in operand register A or B at the clock edge, so the forwarding mux sits in front of those registers and not after them.

Selection is purely combinational from the latched decode fields. A stage may forward only while its write-enable flag is set, and only when its destination is not register 0. Register 0 is hard-wired to zero, so an all-zero no-operation instruction needs no special treatment. When both later stages target the same source register, the younger execute-stage value wins. The register file is taken to return the value being written in the same cycle, so a writeback-stage value needs no fourth mux input. Any producer that writes a register, such as a shifter or a link address, is expected to be merged into the stage result bus upstream.

Top module: `operand_bypass`

## Requirements
- R1: While rstN is low, opA and opB read zero, whatever the data inputs carry.
- R2: When a source index matches no enabled later-stage destination, the operand register takes the register-file value on the next rising edge.
- R3: When a nonzero source index equals exDstIdx and exWrEn is 1, the operand register takes exResult on the next rising edge.
- R4: When a nonzero source index equals memDstIdx, memWrEn is 1, and the execute stage does not match, the operand register takes memResult on the next rising edge.
- R5: When both stages are enabled and both destinations equal the same nonzero source index, exResult is taken, not memResult.
- R6: A stage whose write-enable is 0 is never forwarded, even when its destination index matches.
- R7: A source index of 0 always takes the register-file value, even when an enabled stage targets register 0.
- R8: Operands A and B are selected independently; in one cycle A may take one source and B another.
- R9: The operands are registered: a change of any input between rising edges does not reach opA or opB until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIdxA | input | IDX_W | Source register number for operand A |
| srcIdxB | input | IDX_W | Source register number for operand B |
| rfDataA | input | DATA_W | Register-file read value for operand A |
| rfDataB | input | DATA_W | Register-file read value for operand B |
| exDstIdx | input | IDX_W | Destination number of the execute-stage instruction |
| exWrEn | input | 1 | Execute-stage instruction writes a register |
| exResult | input | DATA_W | Execute-stage result bus |
| memDstIdx | input | IDX_W | Destination number of the memory-stage instruction |
| memWrEn | input | 1 | Memory-stage instruction writes a register |
| memResult | input | DATA_W | Memory-stage result bus |
| opA | output | DATA_W | Registered operand A |
| opB | output | DATA_W | Registered operand B |

## Verification
The two functions that meet in one cycle are the execute-stage match and the memory-stage match for the same operand, which is where the priority decision of R5 lives, together with the register-0 rule of R7 that can coincide with either. The bench provokes both with directed cases and with random stimulus that draws register numbers from a small range so that both destinations often equal a source. Each captured operand is judged against a bench function that applies the priority order written in the requirements, with a tag for the path that should have won.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  // Source chosen for one operand register.
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EX  = 2'd1,
    SEL_MEM = 2'd2
  } opSel_e;

  // Strobes passed from the select control to the operand datapath.
  typedef struct packed {
    opSel_e selA;
    opSel_e selB;
  } fwdStrobes_t;

  localparam int NUM_OPS = 2;

endpackage

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] srcIdxA,
  input  logic [IDX_W-1:0] srcIdxB,
  input  logic [IDX_W-1:0] exDstIdx,
  input  logic             exWrEn,
  input  logic [IDX_W-1:0] memDstIdx,
  input  logic             memWrEn,
  output fwdStrobes_t      strobes
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic [IDX_W-1:0] srcIdx  [NUM_OPS];
  opSel_e           laneSel [NUM_OPS];

  // A stage is a usable producer only when it writes and does not target r0.
  logic exLive;
  logic memLive;

  assign exLive  = exWrEn  && (exDstIdx  != ZERO_IDX);
  assign memLive = memWrEn && (memDstIdx != ZERO_IDX);

  assign srcIdx[0] = srcIdxA;
  assign srcIdx[1] = srcIdxB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
    logic exHit;
    logic memHit;

    assign exHit  = exLive  && (exDstIdx  == srcIdx[g]);
    assign memHit = memLive && (memDstIdx == srcIdx[g]);

    // Younger result first, then older, then the register file.
    always_comb begin
      if (exHit) begin
        laneSel[g] = SEL_EX;
      end else if (memHit) begin
        laneSel[g] = SEL_MEM;
      end else begin
        laneSel[g] = SEL_RF;
      end
    end
  end

  assign strobes.selA = laneSel[0];
  assign strobes.selB = laneSel[1];

  // R7: register 0 is never a forwarding target.
  assert_zero_reg_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (srcIdxA == ZERO_IDX) |-> (strobes.selA == SEL_RF));

  assert_zero_reg_b_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (srcIdxB == ZERO_IDX) |-> (strobes.selB == SEL_RF));

  // R6: with both stages idle only the register file can be chosen.
  assert_idle_stages_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (!exWrEn && !memWrEn) |-> (strobes.selA == SEL_RF && strobes.selB == SEL_RF));

  // R5: a memory pick for A implies the execute stage did not match A.
  assert_priority_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selA == SEL_MEM) |-> !(exWrEn && exDstIdx == srcIdxA));

endmodule

// File: rtl/bypass_datapath.sv
module bypass_datapath
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] exResult,
  input  logic [DATA_W-1:0] memResult,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);

  opSel_e            laneSel [NUM_OPS];
  logic [DATA_W-1:0] rfData  [NUM_OPS];
  logic [DATA_W-1:0] muxOut  [NUM_OPS];
  logic [DATA_W-1:0] opReg   [NUM_OPS];

  assign laneSel[0] = strobes.selA;
  assign laneSel[1] = strobes.selB;
  assign rfData[0]  = rfDataA;
  assign rfData[1]  = rfDataB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
    // Three-way forwarding mux ahead of the operand register.
    always_comb begin
      unique case (laneSel[g])
        SEL_EX:  muxOut[g] = exResult;
        SEL_MEM: muxOut[g] = memResult;
        default: muxOut[g] = rfData[g];
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opReg[g] <= '0;
      end else begin
        opReg[g] <= muxOut[g];
      end
    end
  end

  assign opA = opReg[0];
  assign opB = opReg[1];

  // R1: operands hold zero while reset is applied.
  always_comb begin
    if (rstN === 1'b0) begin
      assert_reset_zero_R1 : assert (opA == '0 && opB == '0);
    end
  end

  // R3: an execute pick lands in the register one edge later.
  assert_ex_path_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selA == SEL_EX) |=> (opA == $past(exResult)));

  // R4: a memory pick lands in the register one edge later.
  assert_mem_path_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selB == SEL_MEM) |=> (opB == $past(memResult)));

  // R2: a register-file pick lands in the register one edge later.
  assert_rf_path_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selA == SEL_RF) |=> (opA == $past(rfDataA)));

  // R8: the control never emits the unused select code on either lane.
  assert_sel_legal_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selA != 2'd3) && (strobes.selB != 2'd3));

endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  srcIdxA,
  input  logic [IDX_W-1:0]  srcIdxB,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [IDX_W-1:0]  exDstIdx,
  input  logic              exWrEn,
  input  logic [DATA_W-1:0] exResult,
  input  logic [IDX_W-1:0]  memDstIdx,
  input  logic              memWrEn,
  input  logic [DATA_W-1:0] memResult,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB
);

  fwdStrobes_t strobes;

  bypass_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srcIdxA   (srcIdxA),
    .srcIdxB   (srcIdxB),
    .exDstIdx  (exDstIdx),
    .exWrEn    (exWrEn),
    .memDstIdx (memDstIdx),
    .memWrEn   (memWrEn),
    .strobes   (strobes)
  );

  bypass_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rfDataA   (rfDataA),
    .rfDataB   (rfDataB),
    .exResult  (exResult),
    .memResult (memResult),
    .opA       (opA),
    .opB       (opB)
  );

endmodule

// File: tb/operand_bypass_bench.sv
`timescale 1ns/1ps
module operand_bypass_bench;

  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;
  localparam int RANDOM_CYCLES = 500;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [IDX_W-1:0]  srcIdxA = '0;
  logic [IDX_W-1:0]  srcIdxB = '0;
  logic [DATA_W-1:0] rfDataA = '0;
  logic [DATA_W-1:0] rfDataB = '0;
  logic [IDX_W-1:0]  exDstIdx = '0;
  logic              exWrEn = 1'b0;
  logic [DATA_W-1:0] exResult = '0;
  logic [IDX_W-1:0]  memDstIdx = '0;
  logic              memWrEn = 1'b0;
  logic [DATA_W-1:0] memResult = '0;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #10 clk = ~clk;

  operand_bypass #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_operand_bypass (
    .clk(clk), .rstN(rstN),
    .srcIdxA(srcIdxA), .srcIdxB(srcIdxB),
    .rfDataA(rfDataA), .rfDataB(rfDataB),
    .exDstIdx(exDstIdx), .exWrEn(exWrEn), .exResult(exResult),
    .memDstIdx(memDstIdx), .memWrEn(memWrEn), .memResult(memResult),
    .opA(opA), .opB(opB)
  );

  // Expected operand from the requirement priority order.
  function automatic logic [DATA_W-1:0] expectOp(
      logic [IDX_W-1:0] src, logic [DATA_W-1:0] rf,
      logic [IDX_W-1:0] exD, logic exE, logic [DATA_W-1:0] exR,
      logic [IDX_W-1:0] memD, logic memE, logic [DATA_W-1:0] memR);
    if (src != 0 && exE && exD == src) return exR;
    if (src != 0 && memE && memD == src) return memR;
    return rf;
  endfunction

  function automatic string pathTag(logic [IDX_W-1:0] src,
      logic [IDX_W-1:0] exD, logic exE, logic [IDX_W-1:0] memD, logic memE);
    if (src == 0) return "R7";
    if (exE && exD == src && memE && memD == src) return "R5";
    if (exE && exD == src) return "R3";
    if (memE && memD == src) return "R4";
    if ((exD == src) || (memD == src)) return "R6";
    return "R2";
  endfunction

  task automatic check(string tag, string what, logic [DATA_W-1:0] act,
                       logic [DATA_W-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [IDX_W-1:0] sA, logic [IDX_W-1:0] sB,
      logic [DATA_W-1:0] rA, logic [DATA_W-1:0] rB,
      logic [IDX_W-1:0] exD, logic exE, logic [DATA_W-1:0] exR,
      logic [IDX_W-1:0] memD, logic memE, logic [DATA_W-1:0] memR);
    srcIdxA = sA; srcIdxB = sB; rfDataA = rA; rfDataB = rB;
    exDstIdx = exD; exWrEn = exE; exResult = exR;
    memDstIdx = memD; memWrEn = memE; memResult = memR;
  endtask

  // Apply inputs at a falling edge, then judge the operands one edge later.
  task automatic step(string tagA, string tagB);
    logic [DATA_W-1:0] expA;
    logic [DATA_W-1:0] expB;
    expA = expectOp(srcIdxA, rfDataA, exDstIdx, exWrEn, exResult,
                    memDstIdx, memWrEn, memResult);
    expB = expectOp(srcIdxB, rfDataB, exDstIdx, exWrEn, exResult,
                    memDstIdx, memWrEn, memResult);
    @(posedge clk);
    @(negedge clk);
    check(tagA, "opA", opA, expA);
    check(tagB, "opB", opB, expB);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));

    // R1: reset holds operands at zero despite live inputs.
    drive(5'd3, 5'd4, 32'hDEAD_0001, 32'hDEAD_0002, 5'd3, 1'b1, 32'h1111_1111,
          5'd4, 1'b1, 32'h2222_2222);
    repeat (3) @(negedge clk);
    check("R1", "opA in reset", opA, '0);
    check("R1", "opB in reset", opB, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: no matches, both from register file.
    drive(5'd1, 5'd2, 32'hA000_0001, 32'hB000_0002, 5'd7, 1'b1, 32'h1,
          5'd8, 1'b1, 32'h2);
    step("R2", "R2");

    // R3: execute match on A; R4: memory match on B; R8 independent lanes.
    drive(5'd5, 5'd6, 32'h0000_0055, 32'h0000_0066, 5'd5, 1'b1, 32'hE0E0_E0E0,
          5'd6, 1'b1, 32'hF0F0_F0F0);
    step("R3", "R8");

    drive(5'd9, 5'd9, 32'h99, 32'h9A, 5'd1, 1'b1, 32'h1234, 5'd9, 1'b1, 32'hCAFE_0009);
    step("R4", "R4");

    // R5: both stages target the same source, execute wins.
    drive(5'd12, 5'd12, 32'hC, 32'hD, 5'd12, 1'b1, 32'h0EEE_0012, 5'd12, 1'b1,
          32'h0AAA_0012);
    step("R5", "R5");

    // R6: matches present but write-enables clear.
    drive(5'd13, 5'd14, 32'h1300_0000, 32'h1400_0000, 5'd13, 1'b0, 32'hBAD1,
          5'd14, 1'b0, 32'hBAD2);
    step("R6", "R6");

    // R6: disabled execute match falls through to enabled memory match.
    drive(5'd15, 5'd15, 32'h15, 32'h16, 5'd15, 1'b0, 32'hBAD3, 5'd15, 1'b1,
          32'h0000_F00D);
    step("R6", "R6");

    // R7: register 0 sources ignore stages targeting register 0.
    drive(5'd0, 5'd0, 32'h0, 32'h0, 5'd0, 1'b1, 32'h7777_7777, 5'd0, 1'b1,
          32'h8888_8888);
    step("R7", "R7");
    drive(5'd0, 5'd0, 32'h0000_0A0A, 32'h0000_0B0B, 5'd0, 1'b1, 32'h7777_7777,
          5'd0, 1'b1, 32'h8888_8888);
    step("R7", "R7");

    // R9: inputs changed between edges do not reach the operands early.
    drive(5'd2, 5'd3, 32'h0202_0202, 32'h0303_0303, 5'd20, 1'b0, 32'h0,
          5'd21, 1'b0, 32'h0);
    step("R9", "R9");
    drive(5'd2, 5'd3, 32'h5555_5555, 32'h6666_6666, 5'd2, 1'b1, 32'h4444_4444,
          5'd3, 1'b1, 32'h3333_3333);
    #3;
    check("R9", "opA held", opA, 32'h0202_0202);
    check("R9", "opB held", opB, 32'h0303_0303);
    @(negedge clk);
    step("R3", "R4");

    // Random mix with small index range to provoke coincident matches.
    for (int i = 0; i < RANDOM_CYCLES; i++) begin
      logic [IDX_W-1:0] sA;
      logic [IDX_W-1:0] sB;
      logic [IDX_W-1:0] eD;
      logic [IDX_W-1:0] mD;
      logic eE;
      logic mE;
      sA = IDX_W'($urandom_range(0, 3));
      sB = IDX_W'($urandom_range(0, 3));
      eD = IDX_W'($urandom_range(0, 3));
      mD = IDX_W'($urandom_range(0, 3));
      eE = 1'($urandom_range(0, 1));
      mE = 1'($urandom_range(0, 1));
      drive(sA, sB, $urandom, $urandom, eD, eE, $urandom, mD, mE, $urandom);
      step(pathTag(sA, eD, eE, mD, mE), pathTag(sB, eD, eE, mD, mE));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule